// File: doc/BRIEF.md
# Dual-channel converter output formatter

This block sits between a two-channel sampling converter core and the chip's output pins. Each clock, every channel delivers a signed raw sample that may exceed the 14-bit range. The block clamps the sample to the 14-bit end codes and raises an overrange flag for any clamped sample. It then holds the clamped word for a pipeline latency chosen between a short and a long depth, and recodes it as twos complement, offset binary or Gray code.

The two channels leave the block as one interleaved stream. A word for the rising half of the output clock normally carries channel A, and a word for the falling half normally carries channel B. Each channel can be switched off on its own. When exactly one channel is off, the other channel's word and flag fill both halves. A global active-low enable input and the per-channel switches together drive one tri-state enable indication. The overrange flag runs on its own short pipeline that does not depend on the data latency.

Format, latency and channel switches are written through a small write-only register port. Any write to the latency register empties the data pipeline. A valid flag stays low until a fresh sample has crossed the whole selected depth.

Top module: `dual_adc_ofmt`

## Requirements
- R1: While `rst_n` is low, `dout_rise`, `dout_fall`, `or_rise`, `or_fall`, `drv_en` and `dout_vld` are all 0. Reset selects twos complement and the short latency, with both channels switched on.
- R2: Format register (address 0, bits [1:0]) value 1, the reset value, gives twos complement. Negative full scale is 0x2000, zero is 0x0000 and positive full scale is 0x1FFF. Raw inputs above 8191 clamp to 0x1FFF and raw inputs below -8192 clamp to 0x2000. The reserved value 3 also gives twos complement.
- R3: Format value 0 gives offset binary, which is the twos complement word with bit 13 inverted. Negative full scale is 0x0000, midscale is 0x2000 and positive full scale is 0x3FFF.
- R4: Format value 2 gives Gray code. The offset binary word b is sent as b ^ (b >> 1), so bit 13 passes through unchanged.
- R5: Latency register (address 1) bit 0 chooses the depth: 0 gives 23 cycles and 1 gives 43 cycles. A sample driven in cycle t appears on the outputs in cycle t+23 or t+43.
- R6: A write to address 1 in cycle w empties the data pipeline. `dout_vld` goes low from cycle w+1, and both data words read 0 whenever `dout_vld` is low. The sample driven in cycle w is dropped. The sample driven in cycle w+1 is the first valid output, in cycle w+1+L, where L is the new depth. After reset release, the sample driven in the release cycle r is the first valid output, in cycle r+L.
- R7: A sample's overrange flag is 1 exactly when its raw value is above 8191 or below -8192. The flag appears 10 cycles after the sample is driven, whatever the latency mode, and a latency write does not clear it.
- R8: Bit 4 of the channel control registers (address 2 for channel A, address 3 for channel B) switches that channel off when set. The other bits are ignored. With both channels on, the rising word and flag carry A and the falling word and flag carry B. With exactly one channel off, both halves carry the channel that is on.
- R9: When both channels are off, or when `oe_n` is high, `drv_en` is 0 and both data words and both flags are 0. A change of `oe_n` in cycle t takes effect in cycle t+1. A register change written in cycle w takes effect in cycle w+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_a | input | 16 | Raw signed sample, channel A |
| samp_b | input | 16 | Raw signed sample, channel B |
| oe_n | input | 1 | Global output disable, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| dout_rise | output | 14 | Word for the rising half of the output clock |
| dout_fall | output | 14 | Word for the falling half of the output clock |
| or_rise | output | 1 | Overrange flag, rising half |
| or_fall | output | 1 | Overrange flag, falling half |
| drv_en | output | 1 | Output drivers enabled (tri-state indication) |
| dout_vld | output | 1 | Data words carry pipeline samples |

## Verification
The overrange pipeline and the data flush can both be active in the same cycle. The bench drives out-of-range samples on both channels in the cycles just before a latency write. Their flags then emerge 10 cycles later, while the data pipeline is still refilling. The scoreboard expects flags high while `dout_vld` is low and the data words are zero, and it expects every flag from the dropped sample in the write cycle as well.

// File: rtl/ofmt_pkg.sv
`timescale 1ns/1ps
package ofmt_pkg;
   typedef enum logic [1:0] {
      FMT_OFFBIN = 2'd0,
      FMT_TWOS   = 2'd1,
      FMT_GRAY   = 2'd2,
      FMT_RSVD   = 2'd3
   } fmt_e;

   localparam int ADDR_FMT    = 0;
   localparam int ADDR_LAT    = 1;
   localparam int ADDR_CTL_A  = 2;
   localparam int ADDR_CTL_B  = 3;
   localparam int CTL_OFF_BIT = 4;
endpackage

// File: rtl/ofmt_cfg_regs.sv
`timescale 1ns/1ps
module ofmt_cfg_regs
   import ofmt_pkg::*;
#(
   parameter int CFG_AW = 2,
   parameter int CFG_DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output fmt_e              fmt,
   output logic              lat_long,
   output logic              off_a,
   output logic              off_b,
   output logic              flush
);
   logic hit_fmt, hit_lat, hit_a, hit_b;

   assign hit_fmt = cfg_we && (cfg_addr == CFG_AW'(ADDR_FMT));
   assign hit_lat = cfg_we && (cfg_addr == CFG_AW'(ADDR_LAT));
   assign hit_a   = cfg_we && (cfg_addr == CFG_AW'(ADDR_CTL_A));
   assign hit_b   = cfg_we && (cfg_addr == CFG_AW'(ADDR_CTL_B));
   assign flush   = hit_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt      <= FMT_TWOS;
         lat_long <= 1'b0;
         off_a    <= 1'b0;
         off_b    <= 1'b0;
      end else begin
         if (hit_fmt) fmt      <= fmt_e'(cfg_wdata[1:0]);
         if (hit_lat) lat_long <= cfg_wdata[0];
         if (hit_a)   off_a    <= cfg_wdata[CTL_OFF_BIT];
         if (hit_b)   off_b    <= cfg_wdata[CTL_OFF_BIT];
      end
   end
endmodule

// File: rtl/ofmt_clamp.sv
`timescale 1ns/1ps
module ofmt_clamp #(
   parameter int IN_W   = 16,
   parameter int DATA_W = 14
) (
   input  logic signed [IN_W-1:0]   raw,
   output logic        [DATA_W-1:0] code,
   output logic                     ovr
);
   localparam logic signed [IN_W-1:0] POS_FS = IN_W'((2 ** (DATA_W - 1)) - 1);
   localparam logic signed [IN_W-1:0] NEG_FS = ~POS_FS;

   logic hi, lo;

   assign hi   = raw > POS_FS;
   assign lo   = raw < NEG_FS;
   assign ovr  = hi | lo;
   assign code = hi ? POS_FS[DATA_W-1:0] :
                 lo ? NEG_FS[DATA_W-1:0] : raw[DATA_W-1:0];
endmodule

// File: rtl/ofmt_dly_line.sv
`timescale 1ns/1ps
module ofmt_dly_line #(
   parameter int W     = 14,
   parameter int DEPTH = 42,
   parameter int TAP0  = 21,
   parameter int TAP1  = 41
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic [W-1:0] din,
   input  logic         sel,
   output logic [W-1:0] dout
);
   logic [W-1:0] stg [DEPTH];

   if (TAP0 >= DEPTH || TAP1 >= DEPTH) begin : g_bad_tap
      $error("ofmt_dly_line: tap outside the line");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      end else if (flush) begin
         for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      end
   end

   if (TAP0 == TAP1) begin : g_fixed
      logic unused_sel;
      assign unused_sel = sel;
      assign dout = stg[TAP0];
   end else begin : g_dual
      assign dout = sel ? stg[TAP1] : stg[TAP0];
   end
endmodule

// File: rtl/ofmt_lane_mux.sv
`timescale 1ns/1ps
module ofmt_lane_mux
   import ofmt_pkg::*;
#(
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_e              fmt,
   input  logic              off_a,
   input  logic              off_b,
   input  logic              oe_n,
   input  logic              vld_nxt,
   input  logic [DATA_W-1:0] tap_a,
   input  logic [DATA_W-1:0] tap_b,
   input  logic              ovr_a,
   input  logic              ovr_b,
   output logic [DATA_W-1:0] dout_rise,
   output logic [DATA_W-1:0] dout_fall,
   output logic              or_rise,
   output logic              or_fall,
   output logic              drv_en
);
   localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

   function automatic logic [DATA_W-1:0] recode(input logic [DATA_W-1:0] t, input fmt_e f);
      logic [DATA_W-1:0] ob;
      ob = t ^ MSB_MASK;
      case (f)
         FMT_OFFBIN: return ob;
         FMT_GRAY:   return ob ^ (ob >> 1);
         default:    return t;
      endcase
   endfunction

   logic              en_a, en_b;
   logic [DATA_W-1:0] code_a, code_b, rise_w, fall_w;
   logic              orr_w, orf_w;

   assign en_a   = !oe_n && !off_a;
   assign en_b   = !oe_n && !off_b;
   assign code_a = recode(tap_a, fmt);
   assign code_b = recode(tap_b, fmt);
   assign rise_w = en_a ? code_a : (en_b ? code_b : '0);
   assign fall_w = en_b ? code_b : (en_a ? code_a : '0);
   assign orr_w  = en_a ? ovr_a : (en_b ? ovr_b : 1'b0);
   assign orf_w  = en_b ? ovr_b : (en_a ? ovr_a : 1'b0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_rise <= '0;
         dout_fall <= '0;
         or_rise   <= 1'b0;
         or_fall   <= 1'b0;
         drv_en    <= 1'b0;
      end else begin
         dout_rise <= vld_nxt ? rise_w : '0;
         dout_fall <= vld_nxt ? fall_w : '0;
         or_rise   <= orr_w;
         or_fall   <= orf_w;
         drv_en    <= en_a | en_b;
      end
   end
endmodule

// File: rtl/dual_adc_ofmt.sv
`timescale 1ns/1ps
module dual_adc_ofmt
   import ofmt_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter int DATA_W    = 14,
   parameter int LAT_SHORT = 23,
   parameter int LAT_LONG  = 43,
   parameter int OR_LAT    = 10,
   parameter int CFG_AW    = 2,
   parameter int CFG_DW    = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [IN_W-1:0]   samp_a,
   input  logic signed [IN_W-1:0]   samp_b,
   input  logic                     oe_n,
   input  logic                     cfg_we,
   input  logic        [CFG_AW-1:0] cfg_addr,
   input  logic        [CFG_DW-1:0] cfg_wdata,
   output logic        [DATA_W-1:0] dout_rise,
   output logic        [DATA_W-1:0] dout_fall,
   output logic                     or_rise,
   output logic                     or_fall,
   output logic                     drv_en,
   output logic                     dout_vld
);
   localparam int NCH       = 2;
   localparam int DLY_DEPTH = LAT_LONG - 1;
   localparam int TAP_S     = LAT_SHORT - 2;
   localparam int TAP_L     = LAT_LONG - 2;
   localparam int OR_DEPTH  = OR_LAT - 1;
   localparam int OR_TAP    = OR_LAT - 2;
   localparam int CNT_W     = $clog2(LAT_LONG);
   localparam logic [CNT_W-1:0] LIM_S = CNT_W'(LAT_SHORT - 1);
   localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LAT_LONG - 1);

   if (LAT_SHORT < 2 || LAT_LONG <= LAT_SHORT) begin : g_bad_lat
      $error("dual_adc_ofmt: latencies must satisfy 2 <= short < long");
   end
   if (OR_LAT < 2) begin : g_bad_or
      $error("dual_adc_ofmt: overrange latency below 2");
   end
   if (IN_W <= DATA_W || IN_W > 32) begin : g_bad_w
      $error("dual_adc_ofmt: raw width must exceed data width and fit 32 bits");
   end
   if (CFG_AW < 2 || CFG_DW <= CTL_OFF_BIT) begin : g_bad_cfg
      $error("dual_adc_ofmt: register port too narrow");
   end

   fmt_e fmt;
   logic lat_long, off_a, off_b, flush;

   ofmt_cfg_regs #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) cfg_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .fmt(fmt), .lat_long(lat_long),
      .off_a(off_a), .off_b(off_b), .flush(flush)
   );

   logic signed [IN_W-1:0]   raw     [NCH];
   logic        [DATA_W-1:0] clip    [NCH];
   logic        [DATA_W-1:0] tap     [NCH];
   logic                     ovr     [NCH];
   logic                     ovr_tap [NCH];

   assign raw[0] = samp_a;
   assign raw[1] = samp_b;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      ofmt_clamp #(.IN_W(IN_W), .DATA_W(DATA_W)) clamp_i (
         .raw(raw[ch]), .code(clip[ch]), .ovr(ovr[ch])
      );
      ofmt_dly_line #(.W(DATA_W), .DEPTH(DLY_DEPTH), .TAP0(TAP_S), .TAP1(TAP_L)) data_dly_i (
         .clk(clk), .rst_n(rst_n), .flush(flush), .din(clip[ch]),
         .sel(lat_long), .dout(tap[ch])
      );
      ofmt_dly_line #(.W(1), .DEPTH(OR_DEPTH), .TAP0(OR_TAP), .TAP1(OR_TAP)) or_dly_i (
         .clk(clk), .rst_n(rst_n), .flush(1'b0), .din(ovr[ch]),
         .sel(1'b0), .dout(ovr_tap[ch])
      );
   end

   logic [CNT_W-1:0] fill_cnt, fill_lim;
   logic             vld_q, vld_nxt;

   assign fill_lim = lat_long ? LIM_L : LIM_S;
   assign vld_nxt  = !flush && (vld_q || (fill_cnt == fill_lim));
   assign dout_vld = vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_cnt <= '0;
         vld_q    <= 1'b0;
      end else begin
         vld_q <= vld_nxt;
         if (flush)                    fill_cnt <= '0;
         else if (fill_cnt != fill_lim) fill_cnt <= fill_cnt + 1'b1;
      end
   end

   ofmt_lane_mux #(.DATA_W(DATA_W)) lane_i (
      .clk(clk), .rst_n(rst_n), .fmt(fmt), .off_a(off_a), .off_b(off_b),
      .oe_n(oe_n), .vld_nxt(vld_nxt), .tap_a(tap[0]), .tap_b(tap[1]),
      .ovr_a(ovr_tap[0]), .ovr_b(ovr_tap[1]),
      .dout_rise(dout_rise), .dout_fall(dout_fall),
      .or_rise(or_rise), .or_fall(or_fall), .drv_en(drv_en)
   );
endmodule

// File: rtl/ofmt_chk.sv
`timescale 1ns/1ps
module ofmt_chk
   import ofmt_pkg::*;
#(
   parameter int CFG_AW = 2,
   parameter int DATA_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              oe_n,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [DATA_W-1:0] dout_rise,
   input logic [DATA_W-1:0] dout_fall,
   input logic              or_rise,
   input logic              or_fall,
   input logic              drv_en,
   input logic              dout_vld,
   input logic              off_a,
   input logic              off_b
);
   // R6: a latency write drops valid in the next cycle
   p_flush_drops_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CFG_AW'(ADDR_LAT)) |=> !dout_vld);

   // R6: data words are zero while not valid
   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_vld |-> (dout_rise == '0 && dout_fall == '0));

   // R9: global disable silences all outputs one cycle later
   p_global_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oe_n) |-> (!drv_en && dout_rise == '0 && dout_fall == '0 && !or_rise && !or_fall));

   // R9: both channels off drops the driver enable
   p_both_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(off_a && off_b) |-> (!drv_en && !or_rise && !or_fall));

   // R8: single enabled channel fills both halves
   p_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(off_a) != $past(off_b)) && drv_en) |-> (dout_rise == dout_fall && or_rise == or_fall));
endmodule

bind dual_adc_ofmt ofmt_chk #(.CFG_AW(CFG_AW), .DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .dout_rise(dout_rise), .dout_fall(dout_fall), .or_rise(or_rise),
   .or_fall(or_fall), .drv_en(drv_en), .dout_vld(dout_vld),
   .off_a(off_a), .off_b(off_b)
);

// File: tb/dual_adc_ofmt_tb_top.sv
`timescale 1ns/1ps
module dual_adc_ofmt_tb_top;
   localparam int L_S = 23;
   localparam int L_L = 43;
   localparam int ORL = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [15:0] samp_a = '0, samp_b = '0;
   logic               oe_n = 1'b0;
   logic               cfg_we = 1'b0;
   logic [1:0]         cfg_addr = '0;
   logic [7:0]         cfg_wdata = '0;
   logic [13:0]        dout_rise, dout_fall;
   logic               or_rise, or_fall, drv_en, dout_vld;

   always #2.5 clk = ~clk;

   dual_adc_ofmt dut_i (
      .clk(clk), .rst_n(rst_n), .samp_a(samp_a), .samp_b(samp_b), .oe_n(oe_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .dout_rise(dout_rise), .dout_fall(dout_fall), .or_rise(or_rise),
      .or_fall(or_fall), .drv_en(drv_en), .dout_vld(dout_vld)
   );

   typedef struct { int due; int a; int b; } item_t;
   item_t dq[$];
   item_t oq[$];

   int    cyc = 0;
   int    n_chk = 0, n_fail = 0;
   int    sh_fmt = 1, sh_lat = L_S, vld_from = 0, gi = 0;
   bit    sh_off_a = 0, sh_off_b = 0, run = 0, chk_en = 1;
   string cur_req = "R2";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", req, what, cyc, act, exp);
      end
   endtask

   function automatic int clampv(int v);
      if (v > 8191) return 8191;
      if (v < -8192) return -8192;
      return v;
   endfunction

   function automatic int ovr(int v);
      return (v > 8191 || v < -8192) ? 1 : 0;
   endfunction

   function automatic int code(int v, int f);
      int t, ob;
      t  = clampv(v) & 16'h3FFF;
      ob = t ^ 16'h2000;
      if (f == 0) return ob;
      if (f == 2) return ob ^ (ob >> 1);
      return t;
   endfunction

   function automatic int gen_v(int k);
      case (k % 16)
         0: return 8191;
         1: return -8192;
         2: return 0;
         3: return 9000;
         4: return -9000;
         5: return 8192;
         6: return -8193;
         7: return 1;
         default: return ((k * 2749 + 13) % 18000) - 9000;
      endcase
   endfunction

   // monitor: compares outputs against queued expectations
   initial begin
      int  er, ef, eo_r, eo_f, ea, eb;
      bit  ev;
      item_t it;
      forever begin
         @(posedge clk);
         #1;
         if (run) begin
            ea = (!oe_n_sh() && !sh_off_a) ? 1 : 0;
            eb = (!oe_n_sh() && !sh_off_b) ? 1 : 0;
            ev = (cyc >= vld_from);
            er = 0; ef = 0; eo_r = 0; eo_f = 0;
            if (dq.size() > 0 && dq[0].due == cyc) begin
               it = dq.pop_front();
               if (ev) begin
                  er = ea ? code(it.a, sh_fmt) : (eb ? code(it.b, sh_fmt) : 0);
                  ef = eb ? code(it.b, sh_fmt) : (ea ? code(it.a, sh_fmt) : 0);
               end
            end else if (ev && chk_en) begin
               check(1'b0, "R5", "no sample due while valid", 0, 1);
            end
            if (oq.size() > 0 && oq[0].due == cyc) begin
               it = oq.pop_front();
               eo_r = ea ? ovr(it.a) : (eb ? ovr(it.b) : 0);
               eo_f = eb ? ovr(it.b) : (ea ? ovr(it.a) : 0);
            end
            if (chk_en) begin
               check(dout_vld == ev, "R6", "dout_vld", dout_vld, ev);
               check(dout_rise == er, cur_req, "dout_rise", dout_rise, er);
               check(dout_fall == ef, cur_req, "dout_fall", dout_fall, ef);
               check(or_rise == eo_r, cur_req, "or_rise", or_rise, eo_r);
               check(or_fall == eo_f, cur_req, "or_fall", or_fall, eo_f);
               check(drv_en == (ea | eb), cur_req, "drv_en", drv_en, ea | eb);
            end
         end
      end
   end

   bit sh_oe_n = 0;
   function automatic bit oe_n_sh();
      return sh_oe_n;
   endfunction

   task automatic tick(int a, int b, bit push_d, bit we, int addr, int data);
      @(negedge clk);
      if (!rst_n) begin
         rst_n    = 1'b1;
         vld_from = cyc + sh_lat;
         run      = 1;
      end
      samp_a    = 16'(a);
      samp_b    = 16'(b);
      cfg_we    = we;
      cfg_addr  = 2'(addr);
      cfg_wdata = 8'(data);
      if (push_d) dq.push_back('{cyc + sh_lat, a, b});
      oq.push_back('{cyc + ORL, a, b});
   endtask

   task automatic run_n(int n);
      repeat (n) begin
         tick(gen_v(gi), gen_v(gi * 3 + 7), 1, 0, 0, 0);
         gi++;
      end
   endtask

   task automatic set_cfg(int addr, int data);
      chk_en = 0;
      tick(gen_v(gi), gen_v(gi + 9), 1, 1, addr, data);
      gi++;
      if (addr == 0) sh_fmt = data & 3;
      if (addr == 2) sh_off_a = data[4];
      if (addr == 3) sh_off_b = data[4];
      run_n(3);
      chk_en = 1;
   endtask

   task automatic set_lat(int data);
      tick(9000, -9000, 0, 1, 1, data);
      dq.delete();
      sh_lat   = data[0] ? L_L : L_S;
      vld_from = cyc + 1 + sh_lat;
   endtask

   task automatic set_oe(bit v);
      chk_en = 0;
      @(negedge clk);
      oe_n = v;
      sh_oe_n = v;
      dq.push_back('{cyc + sh_lat, gen_v(gi), gen_v(gi)});
      oq.push_back('{cyc + ORL, gen_v(gi), gen_v(gi)});
      samp_a = 16'(gen_v(gi));
      samp_b = 16'(gen_v(gi));
      cfg_we = 1'b0;
      gi++;
      run_n(3);
      chk_en = 1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs held at zero during reset
      check(dout_vld == 0, "R1", "dout_vld in reset", dout_vld, 0);
      check(drv_en == 0, "R1", "drv_en in reset", drv_en, 0);
      check(dout_rise == 0, "R1", "dout_rise in reset", dout_rise, 0);
      check(dout_fall == 0, "R1", "dout_fall in reset", dout_fall, 0);
      check(or_rise == 0 && or_fall == 0, "R1", "flags in reset", or_rise, 0);

      cur_req = "R2";       // twos complement default, short latency
      run_n(50);
      cur_req = "R3";
      set_cfg(0, 0);
      run_n(30);
      cur_req = "R4";
      set_cfg(0, 2);
      run_n(30);
      cur_req = "R2";       // reserved code behaves as twos complement
      set_cfg(0, 3);
      run_n(20);
      set_cfg(0, 1);

      // R7 together with R6: flags emerge during the refill window
      cur_req = "R7";
      tick(9000, -9000, 1, 0, 0, 0);
      tick(-8193, 8192, 1, 0, 0, 0);
      set_lat(1);
      run_n(45);
      cur_req = "R5";       // long latency
      run_n(40);

      cur_req = "R8";
      set_cfg(2, 8'h10);
      run_n(20);
      set_cfg(2, 8'hEF);    // other bits ignored: channel A back on
      run_n(15);
      set_cfg(3, 8'h10);
      run_n(20);
      cur_req = "R9";
      set_cfg(2, 8'h10);
      run_n(15);
      set_cfg(2, 8'h00);
      set_cfg(3, 8'h00);
      set_oe(1);
      run_n(15);
      set_oe(0);
      run_n(15);

      cur_req = "R6";       // back to short latency
      set_lat(0);
      run_n(40);
      cur_req = "R5";
      run_n(30);
      finish_run();
   end
endmodule